// File: doc/BRIEF.md
# Operand-Tracking Computation Unit Manager

This block sits between issue logic and a function unit (a combinational ALU or a multi-cycle engine). Its job is to follow one operation from the cycle it is issued until every result it produces has been written back. It holds `busy_o` for that whole span, so scheduling logic can treat the unit as occupied until no work is left.

On an accepted issue the block stores the operation fields. It then gathers the source operands. Each operand has its own release/go handshake, and each one may answer after any delay and in any order. Operands that are not needed are never requested: A when the zero-A flag is set, B when an immediate is supplied, and any port whose read-skip bit is set. Once every operand is in hand, the block passes them to the function unit over a valid/ready pair and accepts the results over a second valid/ready pair. It then raises a write release for each result the function unit marked valid, and it holds that release until the write grant arrives.

Top module: `cu_op_tracker`

## Requirements
- R1: `busy_o` is low after reset. It rises on the cycle after an issue is accepted in the idle state. It stays high while any read or write is outstanding, and it falls on the cycle after the last write grant. If no result is valid, it falls on the cycle after the function unit hands back its outputs.
- R2: An `issue_i` pulse while `busy_o` is high is ignored. The operation in flight keeps its fields, and the function unit is started only once for it.
- R3: Operation type, invert-A, immediate value and its valid flag, zero-A, and record flag are captured in the issue cycle. Changes on those inputs after the issue cycle have no effect on the operation.
- R4: Source port i holds `rd_rel_o[i]` high until a one-cycle `rd_go_i[i]` arrives. The go may come in the release's first cycle. The word on `src_data_i[i*W +: W]` during the go cycle becomes operand i on `alu_opnd_o[i*W +: W]`.
- R5: A source port whose `read_skip_i` bit is 1 never raises its release, and its operand is presented as zero. The skip input is not stored, and it must be held for as long as `busy_o` is high.
- R6: With zero-A set, source 0 is not requested and operand 0 is zero.
- R7: With the immediate valid, source 1 is not requested and operand 1 equals the captured immediate.
- R8: `alu_in_valid_o` rises only after every required operand has been captured, and it stays high until `alu_in_ready_i` is seen.
- R9: Results are taken when `alu_out_valid_i` is high while `alu_out_ready_o` is high. This may happen in the same cycle the inputs are accepted (zero-latency unit) or any number of cycles later.
- R10: `wrmask_o[j]` equals the function unit's valid bit for result j. Only results with that bit set raise `wr_rel_o[j]`, which stays high until `wr_go_i[j]`. During the go cycle, `dest_o[j*W +: W]` carries the result, and it is zero in other cycles.
- R11: An operation with every source skipped and no valid result completes with no read release and no write release at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Issue strobe, accepted only while idle |
| op_type_i | input | OPW | Operation type |
| op_inv_a_i | input | 1 | Invert operand A flag |
| op_imm_i | input | W | Immediate value |
| op_imm_ok_i | input | 1 | Immediate valid; replaces source 1 |
| op_zero_a_i | input | 1 | Force operand A to zero |
| op_rc_i | input | 1 | Record flag, passed to the function unit |
| read_skip_i | input | NUM_SRC | Per-source skip mask, held while busy |
| busy_o | output | 1 | Operation in flight |
| rd_rel_o | output | NUM_SRC | Per-source read release |
| rd_go_i | input | NUM_SRC | Per-source read go pulse |
| src_data_i | input | NUM_SRC*W | Source data, valid in the go cycle |
| alu_in_valid_o | output | 1 | Operands valid to the function unit |
| alu_in_ready_i | input | 1 | Function unit accepts operands |
| alu_op_type_o | output | OPW | Captured operation type |
| alu_inv_a_o | output | 1 | Captured invert-A flag |
| alu_rc_o | output | 1 | Captured record flag |
| alu_opnd_o | output | NUM_SRC*W | Operands after skip, zero and immediate selection |
| alu_out_valid_i | input | 1 | Function unit results valid |
| alu_out_ready_o | output | 1 | Block accepts results |
| alu_res_i | input | NUM_DST*W | Result words |
| alu_res_ok_i | input | NUM_DST | Per-result valid bits |
| wr_rel_o | output | NUM_DST | Per-result write release |
| wr_go_i | input | NUM_DST | Per-result write go pulse |
| dest_o | output | NUM_DST*W | Result data, driven only in the go cycle |
| wrmask_o | output | NUM_DST | Valid results of the current operation |

## Verification
Some properties are checked on every cycle. Releases are held until their go arrives. A skipped, zero-A or immediate port never requests. A write release implies a set mask bit and a high busy. The function unit's input valid is held until ready. The captured operation stays stable across consecutive busy cycles. Other behaviour only the scenarios can show: that the operand reaching the function unit is the word presented in the go cycle, that every result value and mask matches, that stray issues and later field changes leave the operation untouched, and that busy falls exactly one cycle after the last grant. The sweep covers all skip, zero-A, immediate, record and operation combinations, with staggered delays and with both zero-latency and multi-cycle function units.

// File: rtl/cu_pkg.sv
package cu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_EXEC   = 2'd2,
        ST_DRAIN  = 2'd3
    } cu_state_e;

    typedef struct packed {
        logic inv_a;
        logic zero_a;
        logic imm_ok;
        logic rc;
    } cu_flags_t;

endpackage

// File: rtl/cu_seq.sv
module cu_seq
    import cu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      issue_i,
    input  logic      gather_done_i,
    input  logic      alu_in_ready_i,
    input  logic      alu_out_valid_i,
    input  logic      res_any_ok_i,
    input  logic      drain_left_i,
    output cu_state_e state_o,
    output logic      accept_o,
    output logic      capture_o,
    output logic      alu_in_valid_o,
    output logic      alu_out_ready_o
);

    typedef struct packed {
        cu_state_e st;
        logic      sent;
    } seq_t;

    seq_t q, d;
    logic handed;

    always_comb begin
        d               = q;
        accept_o        = 1'b0;
        capture_o       = 1'b0;
        alu_in_valid_o  = 1'b0;
        alu_out_ready_o = 1'b0;
        handed          = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (issue_i) begin
                    accept_o = 1'b1;
                    d.st     = ST_GATHER;
                    d.sent   = 1'b0;
                end
            end
            ST_GATHER: begin
                if (gather_done_i) d.st = ST_EXEC;
            end
            ST_EXEC: begin
                alu_in_valid_o  = !q.sent;
                alu_out_ready_o = 1'b1;
                handed          = q.sent | alu_in_ready_i;
                if (alu_in_valid_o && alu_in_ready_i) d.sent = 1'b1;
                if (handed && alu_out_valid_i) begin
                    capture_o = 1'b1;
                    d.st      = res_any_ok_i ? ST_DRAIN : ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (!drain_left_i) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.sent <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;

    // R8
    alu_valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_in_valid_o && !alu_in_ready_i |=> alu_in_valid_o);

    // R8
    exec_after_gather_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_in_valid_o |-> (q.st == ST_EXEC));

endmodule

// File: rtl/cu_src_port.sv
module cu_src_port #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         gather_i,
    input  logic         need_i,
    input  logic         go_i,
    input  logic [W-1:0] data_i,
    output logic         rel_o,
    output logic         done_o,
    output logic [W-1:0] val_o
);

    typedef struct packed {
        logic         got;
        logic [W-1:0] val;
    } src_t;

    src_t q, d;
    logic take;

    assign rel_o  = gather_i & need_i & !q.got;
    assign take   = rel_o & go_i;
    assign done_o = !need_i | q.got | take;
    assign val_o  = q.val;

    always_comb begin
        d = q;
        if (start_i) begin
            d.got = 1'b0;
            d.val = '0;
        end else if (take) begin
            d.got = 1'b1;
            d.val = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.got <= 1'b0;
            q.val <= '0;
        end else begin
            q <= d;
        end
    end

    // R4
    rd_rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_o && !go_i |=> rel_o || !need_i);

    // R4
    rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !rel_o);

endmodule

// File: rtl/cu_dst_port.sv
module cu_dst_port #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         load_i,
    input  logic         ok_i,
    input  logic [W-1:0] res_i,
    input  logic         drain_i,
    input  logic         go_i,
    output logic         rel_o,
    output logic [W-1:0] dest_o,
    output logic         mask_o,
    output logic         left_o
);

    typedef struct packed {
        logic         pend;
        logic         mask;
        logic [W-1:0] res;
    } dst_t;

    dst_t q, d;
    logic grant;

    assign rel_o  = drain_i & q.pend;
    assign grant  = rel_o & go_i;
    assign dest_o = grant ? q.res : '0;
    assign mask_o = q.mask;
    assign left_o = q.pend & !grant;

    always_comb begin
        d = q;
        if (start_i) begin
            d.pend = 1'b0;
            d.mask = 1'b0;
            d.res  = '0;
        end else if (load_i) begin
            d.pend = ok_i;
            d.mask = ok_i;
            d.res  = res_i;
        end else if (grant) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.pend <= 1'b0;
            q.mask <= 1'b0;
            q.res  <= '0;
        end else begin
            q <= d;
        end
    end

    // R10
    wr_rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_o && !go_i |=> rel_o);

    // R10
    wr_rel_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_o |-> mask_o);

endmodule

// File: rtl/cu_op_tracker.sv
module cu_op_tracker
    import cu_pkg::*;
#(
    parameter int W       = 16,
    parameter int NUM_SRC = 3,
    parameter int NUM_DST = 2,
    parameter int OPW     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue_i,
    input  logic [OPW-1:0]         op_type_i,
    input  logic                   op_inv_a_i,
    input  logic [W-1:0]           op_imm_i,
    input  logic                   op_imm_ok_i,
    input  logic                   op_zero_a_i,
    input  logic                   op_rc_i,
    input  logic [NUM_SRC-1:0]     read_skip_i,
    output logic                   busy_o,
    output logic [NUM_SRC-1:0]     rd_rel_o,
    input  logic [NUM_SRC-1:0]     rd_go_i,
    input  logic [NUM_SRC*W-1:0]   src_data_i,
    output logic                   alu_in_valid_o,
    input  logic                   alu_in_ready_i,
    output logic [OPW-1:0]         alu_op_type_o,
    output logic                   alu_inv_a_o,
    output logic                   alu_rc_o,
    output logic [NUM_SRC*W-1:0]   alu_opnd_o,
    input  logic                   alu_out_valid_i,
    output logic                   alu_out_ready_o,
    input  logic [NUM_DST*W-1:0]   alu_res_i,
    input  logic [NUM_DST-1:0]     alu_res_ok_i,
    output logic [NUM_DST-1:0]     wr_rel_o,
    input  logic [NUM_DST-1:0]     wr_go_i,
    output logic [NUM_DST*W-1:0]   dest_o,
    output logic [NUM_DST-1:0]     wrmask_o
);

    localparam int SRC_BITS = NUM_SRC * W;
    localparam int DST_BITS = NUM_DST * W;

    typedef struct packed {
        cu_flags_t      flags;
        logic [OPW-1:0] typ;
        logic [W-1:0]   imm;
    } op_t;

    op_t q, d;

    cu_state_e           state;
    logic                accept;
    logic                capture;
    logic [NUM_SRC-1:0]  need;
    logic [NUM_SRC-1:0]  src_done;
    logic [NUM_DST-1:0]  dst_left;
    logic [SRC_BITS-1:0] src_val;
    logic [DST_BITS-1:0] dest_w;

    always_comb begin
        d = q;
        if (accept) begin
            d.flags.inv_a  = op_inv_a_i;
            d.flags.zero_a = op_zero_a_i;
            d.flags.imm_ok = op_imm_ok_i;
            d.flags.rc     = op_rc_i;
            d.typ          = op_type_i;
            d.imm          = op_imm_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    cu_seq u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .issue_i         (issue_i),
        .gather_done_i   (&src_done),
        .alu_in_ready_i  (alu_in_ready_i),
        .alu_out_valid_i (alu_out_valid_i),
        .res_any_ok_i    (|alu_res_ok_i),
        .drain_left_i    (|dst_left),
        .state_o         (state),
        .accept_o        (accept),
        .capture_o       (capture),
        .alu_in_valid_o  (alu_in_valid_o),
        .alu_out_ready_o (alu_out_ready_o)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic special;
        logic [W-1:0] forced;
        if (i == 0) begin : g_a
            assign special = q.flags.zero_a;
            assign forced  = '0;
        end else if (i == 1) begin : g_b
            assign special = q.flags.imm_ok;
            assign forced  = q.imm;
        end else begin : g_plain
            assign special = 1'b0;
            assign forced  = '0;
        end

        assign need[i] = !read_skip_i[i] & !special;

        cu_src_port #(.W(W)) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (accept),
            .gather_i (state == ST_GATHER),
            .need_i   (need[i]),
            .go_i     (rd_go_i[i]),
            .data_i   (src_data_i[i*W +: W]),
            .rel_o    (rd_rel_o[i]),
            .done_o   (src_done[i]),
            .val_o    (src_val[i*W +: W])
        );

        assign alu_opnd_o[i*W +: W] = read_skip_i[i] ? '0 :
                                      special        ? forced :
                                                       src_val[i*W +: W];
    end

    for (genvar j = 0; j < NUM_DST; j++) begin : g_dst
        cu_dst_port #(.W(W)) u_dst (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (accept),
            .load_i  (capture),
            .ok_i    (alu_res_ok_i[j]),
            .res_i   (alu_res_i[j*W +: W]),
            .drain_i (state == ST_DRAIN),
            .go_i    (wr_go_i[j]),
            .rel_o   (wr_rel_o[j]),
            .dest_o  (dest_w[j*W +: W]),
            .mask_o  (wrmask_o[j]),
            .left_o  (dst_left[j])
        );
    end

    assign dest_o        = dest_w;
    assign busy_o        = (state != ST_IDLE);
    assign alu_op_type_o = q.typ;
    assign alu_inv_a_o   = q.flags.inv_a;
    assign alu_rc_o      = q.flags.rc;

    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !busy_o |=> busy_o);

    // R1
    busy_covers_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_rel_o) |-> busy_o);

    // R2
    op_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(alu_op_type_o)));

    // R5
    skip_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rel_o & read_skip_i) == '0);

    // R6
    zero_a_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && q.flags.zero_a |-> !rd_rel_o[0]);

    // R7
    imm_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && q.flags.imm_ok |-> !rd_rel_o[1]);

    // R11
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_rel_o) |-> !(|wr_rel_o));

endmodule

// File: tb/cu_op_tracker_tb_top.sv
module cu_op_tracker_tb_top;

    localparam int W   = 16;
    localparam int NS  = 3;
    localparam int ND  = 2;
    localparam int OPW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            issue;
    logic [OPW-1:0]  op_type;
    logic            op_inv, op_imm_ok, op_za, op_rc;
    logic [W-1:0]    op_imm;
    logic [NS-1:0]   skip;
    logic            busy;
    logic [NS-1:0]   rd_rel;
    logic [NS-1:0]   rd_go;
    logic [NS*W-1:0] src_data;
    logic            a_in_valid, a_in_ready;
    logic [OPW-1:0]  a_op;
    logic            a_inv, a_rc;
    logic [NS*W-1:0] a_opnd;
    logic            a_out_valid, a_out_ready;
    logic [ND*W-1:0] a_res;
    logic [ND-1:0]   a_ok;
    logic [ND-1:0]   wr_rel, wr_go, wmask;
    logic [ND*W-1:0] dest;

    logic         go_r [NS];
    logic [W-1:0] dat_r [NS];
    logic         wgo_r [ND];

    for (genvar i = 0; i < NS; i++) begin : g_pk
        assign rd_go[i]            = go_r[i];
        assign src_data[i*W +: W]  = dat_r[i];
    end
    for (genvar j = 0; j < ND; j++) begin : g_wk
        assign wr_go[j] = wgo_r[j];
    end

    cu_op_tracker #(.W(W), .NUM_SRC(NS), .NUM_DST(ND), .OPW(OPW)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_type_i(op_type),
        .op_inv_a_i(op_inv), .op_imm_i(op_imm), .op_imm_ok_i(op_imm_ok),
        .op_zero_a_i(op_za), .op_rc_i(op_rc), .read_skip_i(skip),
        .busy_o(busy), .rd_rel_o(rd_rel), .rd_go_i(rd_go), .src_data_i(src_data),
        .alu_in_valid_o(a_in_valid), .alu_in_ready_i(a_in_ready),
        .alu_op_type_o(a_op), .alu_inv_a_o(a_inv), .alu_rc_o(a_rc),
        .alu_opnd_o(a_opnd), .alu_out_valid_i(a_out_valid),
        .alu_out_ready_o(a_out_ready), .alu_res_i(a_res), .alu_res_ok_i(a_ok),
        .wr_rel_o(wr_rel), .wr_go_i(wr_go), .dest_o(dest), .wrmask_o(wmask)
    );

    // Function-unit model: op 1 = A'+B+C, op 2 = A'-B-C, other = no result.
    // Result 1 is a flag word (4 positive, 2 negative, 1 zero), valid only with the record flag.
    function automatic logic [2*W+1:0] alu_fn(input logic [OPW-1:0] op, input logic inv,
                                               input logic rc, input logic [W-1:0] a,
                                               input logic [W-1:0] b, input logic [W-1:0] c);
        logic [W-1:0] aa, r0, r1;
        logic [1:0]   ok;
        aa = inv ? ~a : a;
        case (op)
            4'd1:    r0 = aa + b + c;
            4'd2:    r0 = aa - b - c;
            default: r0 = '0;
        endcase
        ok[0] = (op == 4'd1) || (op == 4'd2);
        ok[1] = ok[0] && rc;
        if (!ok[1])          r1 = '0;
        else if (r0 == '0)   r1 = 16'd1;
        else if (r0[W-1])    r1 = 16'd2;
        else                 r1 = 16'd4;
        return {ok, r1, r0};
    endfunction

    int               lat = 0;
    logic             m_busy = 1'b0;
    int               m_cnt = 0;
    logic [2*W+1:0]   m_out = '0;
    logic [2*W+1:0]   comb_out;
    logic [NS*W-1:0]  seen_opnd = '0;
    int               seen_cnt = 0;

    assign comb_out = alu_fn(a_op, a_inv, a_rc, a_opnd[0 +: W], a_opnd[W +: W], a_opnd[2*W +: W]);

    always_comb begin
        if (lat == 0) begin
            a_in_ready  = a_out_ready;
            a_out_valid = a_in_valid;
            a_res       = comb_out[2*W-1:0];
            a_ok        = comb_out[2*W +: 2];
        end else begin
            a_in_ready  = !m_busy;
            a_out_valid = m_busy && (m_cnt == 0);
            a_res       = m_out[2*W-1:0];
            a_ok        = m_out[2*W +: 2];
        end
    end

    always_ff @(posedge clk) begin
        if (a_in_valid && a_in_ready) begin
            seen_opnd <= a_opnd;
            seen_cnt  <= seen_cnt + 1;
        end
        if (lat != 0) begin
            if (a_in_valid && a_in_ready) begin
                m_busy <= 1'b1;
                m_cnt  <= lat - 1;
                m_out  <= comb_out;
            end else if (m_busy && m_cnt != 0) begin
                m_cnt <= m_cnt - 1;
            end else if (m_busy && a_out_ready) begin
                m_busy <= 1'b0;
            end
        end
    end

    int checks = 0;
    int fails  = 0;
    logic [NS-1:0] exp_rd = '0;
    logic [ND-1:0] exp_wr = '0;
    int stray = 0;
    logic [W-1:0] exp_dest [ND];
    logic [ND-1:0] exp_mask;

    always @(negedge clk) begin
        for (int i = 0; i < NS; i++) if (rd_rel[i] && !exp_rd[i]) stray = stray + 1;
        for (int j = 0; j < ND; j++) if (wr_rel[j] && !exp_wr[j]) stray = stray + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic produce(input int k, input logic [W-1:0] v, input int dly);
        while (!rd_rel[k]) @(negedge clk);
        repeat (dly) @(negedge clk);
        go_r[k]  = 1'b1;
        dat_r[k] = v;
        @(negedge clk);
        go_r[k]  = 1'b0;
        dat_r[k] = '0;
    endtask

    task automatic consume(input int k, input int dly);
        while (!wr_rel[k]) @(negedge clk);
        repeat (dly) @(negedge clk);
        wgo_r[k] = 1'b1;
        #1;
        check(dest[k*W +: W] == exp_dest[k], "R10 dest", dest[k*W +: W], exp_dest[k]);
        check(wmask == exp_mask, "R10 wrmask", wmask, exp_mask);
        @(negedge clk);
        wgo_r[k] = 1'b0;
        #1;
        check(dest[k*W +: W] == '0, "R10 dest idle", dest[k*W +: W], 0);
    endtask

    task automatic stray_issue();
        if (busy) begin
            issue = 1'b1;
            op_type = 4'd2;
            op_imm = 16'h1234;
            @(negedge clk);
            issue = 1'b0;
        end
    endtask

    task automatic run_op(input int n, input logic [OPW-1:0] op, input logic [NS-1:0] sk,
                          input logic za, input logic im, input logic rc);
        logic [W-1:0] a, b, c, imm, ae, be, ce;
        logic [2*W+1:0] e;
        logic inv;
        int s0, c0, lim;
        a   = 16'h0100 + W'(n * 7);
        b   = 16'h0005 + W'(n * 3);
        c   = W'(n) ^ 16'h0055;
        imm = 16'h0040 + W'(n);
        inv = (n % 3) == 1;
        ae  = (sk[0] || za) ? '0 : a;
        be  = sk[1] ? '0 : (im ? imm : b);
        ce  = sk[2] ? '0 : c;
        e   = alu_fn(op, inv, rc, ae, be, ce);
        exp_rd      = {!sk[2], !sk[1] && !im, !sk[0] && !za};
        exp_wr      = e[2*W +: 2];
        exp_mask    = e[2*W +: 2];
        exp_dest[0] = e[W-1:0];
        exp_dest[1] = e[2*W-1:W];
        s0 = stray;
        c0 = seen_cnt;
        skip = sk;
        op_type = op; op_inv = inv; op_imm = imm; op_imm_ok = im; op_za = za; op_rc = rc;
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        // R3: fields scrambled right after the issue cycle
        op_type = 4'hF; op_inv = !inv; op_imm = 16'hFFFF; op_imm_ok = !im; op_za = !za; op_rc = !rc;
        check(busy == 1'b1, "R1 busy rise", busy, 1);
        fork
            begin if (exp_rd[0]) produce(0, a, n % 3); end
            begin if (exp_rd[1]) produce(1, b, (n / 3) % 3); end
            begin if (exp_rd[2]) produce(2, c, (n + 1) % 3); end
            begin if (exp_wr[0]) consume(0, (n / 2) % 3); end
            begin if (exp_wr[1]) consume(1, (n + 2) % 3); end
            begin @(negedge clk); stray_issue(); end
        join
        if (exp_wr != '0) begin
            check(busy == 1'b0, "R1 busy fall after last grant", busy, 0);
        end else begin
            lim = 0;
            while (busy && lim < 50) begin @(negedge clk); lim++; end
            check(busy == 1'b0, "R11 completes without writes", busy, 0);
        end
        check(seen_opnd == {ce, be, ae}, "R4 R5 R6 R7 operands", seen_opnd, {ce, be, ae});
        check(seen_cnt - c0 == 1, "R2 R8 R9 single start", seen_cnt - c0, 1);
        check(stray == s0, "R5 R6 R7 R11 no stray release", stray - s0, 0);
        @(negedge clk);
        check(busy == 1'b0, "R2 stray issue ignored", busy, 0);
        skip = '0;
    endtask

    initial begin
        int n;
        issue = 0; op_type = 0; op_inv = 0; op_imm = 0; op_imm_ok = 0; op_za = 0; op_rc = 0; skip = 0;
        for (int i = 0; i < NS; i++) begin go_r[i] = 0; dat_r[i] = 0; end
        for (int j = 0; j < ND; j++) wgo_r[j] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0, "R1 reset busy", busy, 0);
        check(rd_rel == 0 && wr_rel == 0, "R1 reset releases", {rd_rel, wr_rel}, 0);
        check(a_in_valid == 0, "R8 reset alu valid", a_in_valid, 0);
        n = 0;
        for (int l = 0; l < 2; l++) begin
            lat = (l == 0) ? 0 : 3;
            for (int op = 0; op < 3; op++)
                for (int sk = 0; sk < 8; sk++)
                    for (int f = 0; f < 8; f++) begin
                        run_op(n, OPW'(op), NS'(sk), f[0], f[1], f[2]);
                        n++;
                    end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule